// File: doc/BRIEF.md
# Serial Gamma Code Register Loader

This block takes 17-bit command frames from a three-wire serial link (a load strobe, a serial clock and a data line) and stores the 10-bit code each frame carries in one of thirteen registers. Twelve of the registers hold the codes for twelve output channels. The thirteenth register is a spare. When it holds one specific code, the channels are forced to follow their registers. Each complete frame also sets an oscillator-mode select.

The three serial lines and the output-select pin are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and all edge detection happens in the system clock domain. For every channel the block reports a "use preset" flag. When that flag is set, the channel takes a fixed divider tap instead of its register code. The block also reports the tap numerator, where channel k uses reference × (12 − k)/13. The analog divider itself is not modelled.

Top module: `gamma_serial_loader`

## Requirements
- R1: After reset, every channel code reads 0, the oscillator select reads 0 and the override flag reads 0.
- R2: A frame has 17 bits, sent first to last as d0..d16. Bits d2..d6 form the register address, with d2 as the MSB. Bits d7..d16 form the data value, with d7 as the MSB. A frame with exactly 17 serial clock rising edges while the strobe is low writes that data to the addressed register when the strobe rises. Addresses 0..11 drive channels 0..11.
- R3: A frame with fewer than 17 serial clock rising edges while the strobe is low changes no register and does not change the oscillator select.
- R4: A frame with more than 17 edges uses only the last 17 bits received.
- R5: Bit d1 of each accepted frame sets the oscillator select (0 = internal, 1 = external clock), whatever the address.
- R6: Accepted frames with addresses 12..31 change no channel code. Addresses 13..31 write no register at all.
- R7: The value of bit d0 has no effect on the outcome of a frame.
- R8: While register 12 holds 0x2A0, the override flag is 1 and every "use preset" flag is 0, whatever the level of the select pin. Any other value in register 12 gives an override flag of 0.
- R9: Without the override, a high select pin clears every "use preset" flag and a low select pin sets all of them.
- R10: The 4-bit tap numerator of channel k is 12 − k. It is packed at bits [4k+3:4k].
- R11: Serial clock edges that occur while the strobe is high neither shift bits in nor count toward a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_stb_i | input | 1 | Load strobe; low while a frame is sent, rising edge commits |
| sel_pin_i | input | 1 | Output-select pin; high selects the register codes |
| chan_code_o | output | 120 | Channel k code at [10k+9:10k] |
| osc_ext_o | output | 1 | Oscillator select, 1 = external clock |
| override_o | output | 1 | Register 12 holds the override code |
| use_preset_o | output | 12 | Per-channel flag: take the divider tap |
| preset_idx_o | output | 48 | Per-channel tap numerator, 4 bits each |

## Verification
Some properties are checked on every cycle by assertions. The bit counter never passes 17. The shift register holds still while the strobe is high. The register bank changes only on a write pulse. The override flag and the select pin must each clear the preset flags. Other behaviour can only be shown by the bench's frames, checked against a bench model: short frames being dropped, long frames keeping their tail, the address and data bit order, and the oscillator bit coming in from out-of-range addresses. The same holds for the magic-value override and for clock pulses while the strobe is high being ignored.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  localparam int FRAME_LEN = 17;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 10;
  localparam int N_CH      = 12;
  localparam int N_REG     = N_CH + 1;
  localparam int IDX_W     = 4;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [DATA_W-1:0] OVR_CODE = 10'h2A0;
endpackage

// File: rtl/gsl_sync.sv
module gsl_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gsl_shifter.sv
module gsl_shifter
  import gsl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  input  logic                 stb_i,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 commit_o
);
  logic             sclk_q, stb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_LEN-1:0] sr_q;
  logic             sclk_rise, stb_rise, shift_en;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign stb_rise  = stb_i & ~stb_q;
  assign shift_en  = sclk_rise & ~stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      stb_q    <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      commit_o <= 1'b0;
    end else begin
      sclk_q   <= sclk_i;
      stb_q    <= stb_i;
      commit_o <= stb_rise && (cnt_q == CNT_W'(FRAME_LEN));
      if (shift_en) begin
        sr_q <= {sr_q[FRAME_LEN-2:0], sdat_i};
        if (cnt_q != CNT_W'(FRAME_LEN)) cnt_q <= cnt_q + 1'b1;
      end else if (stb_rise) begin
        cnt_q <= '0;
      end
    end
  end

  assign frame_o = sr_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN)); // R4
  AST_NO_SHIFT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> $stable(sr_q)); // R11
  AST_COMMIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cnt_q == '0); // R3
endmodule

// File: rtl/gsl_regbank.sv
module gsl_regbank
  import gsl_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [FRAME_LEN-1:0]    frame_i,
  output logic [N_REG*DATA_W-1:0] regs_o,
  output logic                    osc_ext_o
);
  localparam int DATA_LSB = 0;
  localparam int ADDR_LSB = DATA_W;
  localparam int OSC_POS  = DATA_W + ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  assign addr = frame_i[ADDR_LSB +: ADDR_W];
  assign data = frame_i[DATA_LSB +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_ext_o <= 1'b0;
    else if (wr_i) osc_ext_o <= frame_i[OSC_POS];
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (wr_i && addr == ADDR_W'(g)) regs_o[g*DATA_W +: DATA_W] <= data;
    end
  end

  AST_WRITE_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o)); // R3
  AST_OSC_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(osc_ext_o)); // R5
endmodule

// File: rtl/gsl_outsel.sv
module gsl_outsel
  import gsl_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic [N_REG*DATA_W-1:0] regs_i,
  output logic [N_CH*DATA_W-1:0]  chan_code_o,
  output logic                    override_o,
  output logic [N_CH-1:0]         use_preset_o,
  output logic [N_CH*IDX_W-1:0]   preset_idx_o
);
  assign chan_code_o = regs_i[N_CH*DATA_W-1:0];
  assign override_o  = regs_i[N_CH*DATA_W +: DATA_W] == OVR_CODE;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign use_preset_o[k]               = ~(override_o | sel_i);
    assign preset_idx_o[k*IDX_W +: IDX_W] = IDX_W'(N_CH - k);
  end

  AST_OVR_NO_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_o |-> use_preset_o == '0); // R8
  AST_PIN_NO_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> use_preset_o == '0); // R9
  AST_PRESET_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_preset_o == '0 || &use_preset_o); // R9
endmodule

// File: rtl/gamma_serial_loader.sv
module gamma_serial_loader
  import gsl_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_stb_i,
  input  logic                   sel_pin_i,
  output logic [N_CH*DATA_W-1:0] chan_code_o,
  output logic                   osc_ext_o,
  output logic                   override_o,
  output logic [N_CH-1:0]        use_preset_o,
  output logic [N_CH*IDX_W-1:0]  preset_idx_o
);
  logic [3:0] sync_q;
  logic [FRAME_LEN-1:0] frame;
  logic commit;
  logic [N_REG*DATA_W-1:0] regs;

  gsl_sync #(.W(4)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_pin_i, ser_stb_i, ser_dat_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  gsl_shifter u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sync_q[0]),
    .sdat_i  (sync_q[1]),
    .stb_i   (sync_q[2]),
    .frame_o (frame),
    .commit_o(commit)
  );

  gsl_regbank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (commit),
    .frame_i  (frame),
    .regs_o   (regs),
    .osc_ext_o(osc_ext_o)
  );

  gsl_outsel u_outsel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sync_q[3]),
    .regs_i      (regs),
    .chan_code_o (chan_code_o),
    .override_o  (override_o),
    .use_preset_o(use_preset_o),
    .preset_idx_o(preset_idx_o)
  );
endmodule

// File: tb/gamma_serial_loader_bench.sv
module gamma_serial_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b1, sel_pin = 1'b0;
  logic [119:0] chan_code;
  logic osc_ext, override;
  logic [11:0] use_preset;
  logic [47:0] preset_idx;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [9:0] m_reg [13];
  logic m_osc;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_serial_loader u_gamma_serial_loader (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_stb_i(ser_stb), .sel_pin_i(sel_pin), .chan_code_o(chan_code),
    .osc_ext_o(osc_ext), .override_o(override), .use_preset_o(use_preset),
    .preset_idx_o(preset_idx)
  );

  function automatic logic [16:0] mk_frame(logic d0, logic osc, logic [4:0] a, logic [9:0] d);
    return {d0, osc, a, d};
  endfunction

  function automatic logic [119:0] exp_codes();
    logic [119:0] v;
    for (int k = 0; k < 12; k++) v[k*10 +: 10] = m_reg[k];
    return v;
  endfunction

  function automatic void model_commit(logic [16:0] f);
    m_osc = f[15];
    if (f[14:10] < 5'd13) m_reg[f[14:10]] = f[9:0];
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = 1'($urandom); wait_clk(HALF);
      ser_clk = 1'b1; wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  // sends v[n-1] first
  task automatic send_bits(logic [63:0] v, int n);
    ser_stb = 1'b0; wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i]; wait_clk(HALF);
      ser_clk = 1'b1; wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
    ser_stb = 1'b1;
    wait_clk(8);
  endtask

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic ovr;
    ovr = (m_reg[12] == 10'h2A0);
    check({req, " codes"}, 128'(chan_code), 128'(exp_codes()));
    check({req, " osc"}, 128'(osc_ext), 128'(m_osc));
    check({req, " override"}, 128'(override), 128'(ovr));
    check({req, " preset"}, 128'(use_preset), 128'({12{~(ovr | sel_pin)}}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [16:0] f;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) m_reg[i] = '0;
    m_osc = 1'b0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    check_all("R1 reset");

    for (int k = 0; k < 12; k++)
      check("R10 tap index", 128'(preset_idx[k*4 +: 4]), 128'(12 - k));

    // R2 exact frame, bit order
    f = mk_frame(1'b0, 1'b0, 5'd5, 10'h201);
    send_bits(64'(f), 17); model_commit(f); check_all("R2 write addr5");
    f = mk_frame(1'b0, 1'b0, 5'd11, 10'h3FE);
    send_bits(64'(f), 17); model_commit(f); check_all("R2 write addr11");

    // R3 short frame ignored
    f = mk_frame(1'b0, 1'b1, 5'd0, 10'h155);
    send_bits(64'(f[16:1]), 16); check_all("R3 short frame");

    // R4 long frame keeps last 17
    f = mk_frame(1'b0, 1'b1, 5'd3, 10'h0AB);
    send_bits({40'h0, 7'b1111111, f}, 24); model_commit(f); check_all("R4 long frame");

    // R5/R6 address above range: osc only
    f = mk_frame(1'b0, 1'b0, 5'd31, 10'h3FF);
    send_bits(64'(f), 17); model_commit(f); check_all("R5 R6 addr31");

    // R7 d0 set
    f = mk_frame(1'b1, 1'b1, 5'd7, 10'h2C3);
    send_bits(64'(f), 17); model_commit(f); check_all("R7 d0 high");

    // R11 pulses while strobe high do not count
    idle_pulses(12);
    f = mk_frame(1'b0, 1'b0, 5'd1, 10'h111);
    send_bits(64'(f[16:7]), 10); check_all("R11 strobe-high pulses");

    // R9 pin high
    sel_pin = 1'b1; wait_clk(4); check_all("R9 pin high");
    sel_pin = 1'b0; wait_clk(4); check_all("R9 pin low");

    // R8 override
    f = mk_frame(1'b0, 1'b0, 5'd12, 10'h2A0);
    send_bits(64'(f), 17); model_commit(f); check_all("R8 override set");
    check("R6 reg12 no channel", 128'(chan_code), 128'(exp_codes()));
    sel_pin = 1'b1; wait_clk(4); check_all("R8 override pin high");
    sel_pin = 1'b0;
    f = mk_frame(1'b0, 1'b0, 5'd12, 10'h2A1);
    send_bits(64'(f), 17); model_commit(f); check_all("R8 near-miss code");

    // random mix
    for (int it = 0; it < 60; it++) begin
      f = mk_frame(1'($urandom), 1'($urandom), 5'($urandom), 10'($urandom));
      if ($urandom_range(7) == 0) f[14:10] = 5'd12;
      if ($urandom_range(9) == 0) f[9:0] = 10'h2A0;
      sel_pin = 1'($urandom);
      v = {$urandom, $urandom};
      case ($urandom_range(3))
        0: begin n = $urandom_range(16, 1); send_bits(v, n); check_all("R3 random short"); end
        1: begin n = $urandom_range(24, 18); v[16:0] = f; send_bits(v, n);
                 model_commit(f); check_all("R4 random long"); end
        default: begin send_bits(64'(f), 17); model_commit(f); check_all("R2 random frame"); end
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule